// File: doc/BRIEF.md
# Dual-Rail Three-Valued Gate Set

This block is a small library of combinational logic primitives that operate on three-valued signals: definite 0, definite 1 and unknown. Every such signal travels as a two-bit pair `{hi, lo}`. A definite value has both bits equal. An unknown value has the two bits unequal, and both unknown codes are legal.

The library contains the following pieces:
- an entry encoder that lifts an ordinary binary wire into the pair form;
- a rail-wise inverter;
- two-operand AND, OR, NAND and NOR gates, each selected by a gate-kind parameter;
- a classifier that tells whether a pair is definite and, if it is, which value it carries.

Wider gates are built by chaining the two-operand cells. The wrapper brings one instance of each cell out to ports so that the whole library can be exercised together.

Every gate accepts either unknown code on its inputs. Every gate produces definite results only as `00` or `11`. A definite result appears only when the controlling-value rules fix the output. Otherwise the output is a fixed unknown code that depends on the gate kind.

Top module: `tern_gate_unit`

## Requirements
- R1: Pair code `00` means definite 0, `11` means definite 1, and `01` or `10` means unknown; bit 1 is the high rail and bit 0 is the low rail.
- R2: The encoder maps binary input 0 to `00` and binary input 1 to `11`.
- R3: The inverter flips both rails independently: `00`→`11`, `11`→`00`, `01`→`10`, `10`→`01`.
- R4: AND returns `00` whenever at least one operand is `00`, regardless of the other operand's code.
- R5: AND returns `11` only when both operands are `11`; every other operand pair without a `00` yields the unknown code `10`.
- R6: OR returns `11` whenever at least one operand is `11`, regardless of the other operand's code.
- R7: OR returns `00` only when both operands are `00`; every other operand pair without a `11` yields the unknown code `01`.
- R8: NAND is the rail-wise inverse of AND, and NOR is the rail-wise inverse of OR, for all 16 operand code pairs.
- R9: The classifier raises its unknown flag exactly when the two rails differ; its value output equals the high rail when the pair is definite and is 0 when the pair is unknown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 2 | First operand pair for the gates and the inverter |
| opb_i | input | 2 | Second operand pair for the two-input gates |
| bin_i | input | 1 | Binary value to be encoded |
| cls_i | input | 2 | Pair to be classified |
| enc_o | output | 2 | Encoded form of `bin_i` |
| not_o | output | 2 | Rail-wise inverse of `opa_i` |
| and_o | output | 2 | AND of the operands |
| or_o | output | 2 | OR of the operands |
| nand_o | output | 2 | NAND of the operands |
| nor_o | output | 2 | NOR of the operands |
| cls_unk_o | output | 1 | High when `cls_i` is an unknown code |
| cls_val_o | output | 1 | Definite value of `cls_i`, 0 when unknown |

## Verification
The assertions evaluate the gate outputs whenever the operand wires settle, and they take for granted that all inputs carry only 0 or 1 bits, never X or Z. Because of that assumption, every one of the four pair codes is a meaningful operand. The stimulus drives only two-state values. It changes inputs on the falling clock edge, and the bench compares results on the following rising edge. The bench walks all 16 operand pairs, both encoder inputs and all four classifier codes, so that each unknown code meets each controlling and non-controlling partner.

// File: rtl/tern_pkg.sv
package tern_pkg;

  localparam int RAILS = 2;

  typedef logic [RAILS-1:0] tpair_t;

  typedef enum logic [1:0] {
    GK_AND  = 2'd0,
    GK_OR   = 2'd1,
    GK_NAND = 2'd2,
    GK_NOR  = 2'd3
  } gate_kind_e;

  localparam tpair_t T_ZERO = '0;
  localparam tpair_t T_ONE  = '1;

  function automatic logic is_zero(input tpair_t p);
    return (p == T_ZERO);
  endfunction

  function automatic logic is_one(input tpair_t p);
    return (p == T_ONE);
  endfunction

  function automatic tpair_t rail_inv(input tpair_t p);
    return ~p;
  endfunction

  // High rail drops only on a controlling zero; low rail rises only when both are one.
  function automatic tpair_t tern_and(input tpair_t a, input tpair_t b);
    tpair_t r;
    r[1] = ~(is_zero(a) | is_zero(b));
    r[0] = is_one(a) & is_one(b);
    return r;
  endfunction

  // High rail rises on any controlling one; low rail drops only when both are zero.
  function automatic tpair_t tern_or(input tpair_t a, input tpair_t b);
    tpair_t r;
    r[1] = is_one(a) | is_one(b);
    r[0] = ~(is_zero(a) & is_zero(b));
    return r;
  endfunction

endpackage

// File: rtl/tern_encode.sv
module tern_encode
  import tern_pkg::*;
(
  input  logic   bit_i,
  output tpair_t pair_o
);
  assign pair_o = {RAILS{bit_i}};
endmodule

// File: rtl/tern_not.sv
module tern_not
  import tern_pkg::*;
(
  input  tpair_t a_i,
  output tpair_t y_o
);
  assign y_o = rail_inv(a_i);
endmodule

// File: rtl/tern_gate2.sv
module tern_gate2
  import tern_pkg::*;
#(
  parameter gate_kind_e KIND = GK_AND
) (
  input  tpair_t a_i,
  input  tpair_t b_i,
  output tpair_t y_o
);
  localparam bit USE_AND = (KIND == GK_AND) || (KIND == GK_NAND);
  localparam bit INVERT  = (KIND == GK_NAND) || (KIND == GK_NOR);

  tpair_t core;

  generate
    if (USE_AND) begin : g_and_core
      assign core = tern_and(a_i, b_i);
    end else begin : g_or_core
      assign core = tern_or(a_i, b_i);
    end

    if (INVERT) begin : g_inv
      tern_not u_inv (.a_i(core), .y_o(y_o));
    end else begin : g_pass
      assign y_o = core;
    end
  endgenerate
endmodule

// File: rtl/tern_decode.sv
module tern_decode
  import tern_pkg::*;
(
  input  tpair_t pair_i,
  output logic   unk_o,
  output logic   val_o
);
  assign unk_o = pair_i[1] ^ pair_i[0];
  assign val_o = pair_i[1] & ~unk_o;
endmodule

// File: rtl/tern_gate_unit.sv
module tern_gate_unit
  import tern_pkg::*;
(
  input  logic [1:0] opa_i,
  input  logic [1:0] opb_i,
  input  logic       bin_i,
  input  logic [1:0] cls_i,
  output logic [1:0] enc_o,
  output logic [1:0] not_o,
  output logic [1:0] and_o,
  output logic [1:0] or_o,
  output logic [1:0] nand_o,
  output logic [1:0] nor_o,
  output logic       cls_unk_o,
  output logic       cls_val_o
);
  localparam int NKIND = 4;
  localparam gate_kind_e KINDS [NKIND] = '{GK_AND, GK_OR, GK_NAND, GK_NOR};

  tpair_t gate_y [NKIND];

  tern_encode u_enc (.bit_i(bin_i), .pair_o(enc_o));
  tern_not    u_not (.a_i(opa_i), .y_o(not_o));

  generate
    for (genvar k = 0; k < NKIND; k++) begin : g_gate
      tern_gate2 #(.KIND(KINDS[k])) u_g (
        .a_i(opa_i), .b_i(opb_i), .y_o(gate_y[k])
      );
    end
  endgenerate

  assign and_o  = gate_y[0];
  assign or_o   = gate_y[1];
  assign nand_o = gate_y[2];
  assign nor_o  = gate_y[3];

  tern_decode u_dec (.pair_i(cls_i), .unk_o(cls_unk_o), .val_o(cls_val_o));
endmodule

// File: rtl/tern_gate_chk.sv
module tern_gate_chk (
  input logic [1:0] opa_i,
  input logic [1:0] opb_i,
  input logic       bin_i,
  input logic [1:0] cls_i,
  input logic [1:0] enc_o,
  input logic [1:0] not_o,
  input logic [1:0] and_o,
  input logic [1:0] or_o,
  input logic [1:0] nand_o,
  input logic [1:0] nor_o,
  input logic       cls_unk_o,
  input logic       cls_val_o
);
  wire a_zero = (opa_i == 2'b00);
  wire b_zero = (opb_i == 2'b00);
  wire a_one  = (opa_i == 2'b11);
  wire b_one  = (opb_i == 2'b11);

  always_comb begin
    // R2
    enc_match_chk: assert (enc_o[1] == bin_i && enc_o[0] == bin_i);
    // R3
    not_swap_chk: assert ((not_o ^ opa_i) == 2'b11);
    // R4
    and_ctrl_chk: assert (!(a_zero || b_zero) || and_o == 2'b00);
    // R5
    and_unk_chk: assert (a_zero || b_zero || (a_one && b_one) || and_o == 2'b10);
    // R6
    or_ctrl_chk: assert (!(a_one || b_one) || or_o == 2'b11);
    // R7
    or_unk_chk: assert (a_one || b_one || (a_zero && b_zero) || or_o == 2'b01);
    // R8
    nand_dual_chk: assert ((nand_o ^ and_o) == 2'b11);
    // R8
    nor_dual_chk: assert ((nor_o ^ or_o) == 2'b11);
    // R9
    cls_flag_chk: assert (cls_unk_o == (cls_i == 2'b01 || cls_i == 2'b10));
    // R9
    cls_val_chk: assert (!cls_unk_o || !cls_val_o);
  end
endmodule

bind tern_gate_unit tern_gate_chk u_chk (
  .opa_i(opa_i), .opb_i(opb_i), .bin_i(bin_i), .cls_i(cls_i),
  .enc_o(enc_o), .not_o(not_o), .and_o(and_o), .or_o(or_o),
  .nand_o(nand_o), .nor_o(nor_o), .cls_unk_o(cls_unk_o), .cls_val_o(cls_val_o)
);

// File: tb/tern_gate_unit_tb_top.sv
module tern_gate_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] opa, opb, cls;
  logic       bin;
  logic [1:0] enc, nt, an, orr, nan, nr;
  logic       unk, val;

  tern_gate_unit dut_i (
    .opa_i(opa), .opb_i(opb), .bin_i(bin), .cls_i(cls),
    .enc_o(enc), .not_o(nt), .and_o(an), .or_o(orr),
    .nand_o(nan), .nor_o(nr), .cls_unk_o(unk), .cls_val_o(val)
  );

  typedef enum int { V0, V1, VX } tv_e;

  typedef struct {
    logic [1:0] a, b, c;
    logic       bn;
    logic [1:0] e_enc, e_not, e_and, e_or, e_nand, e_nor;
    logic       e_unk, e_val;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // R1: 00 is 0, 11 is 1, mixed codes are unknown
  function automatic tv_e to_tv(logic [1:0] p);
    if (p == 2'b00) return V0;
    if (p == 2'b11) return V1;
    return VX;
  endfunction

  function automatic logic [1:0] from_tv(tv_e v, logic [1:0] unk_code);
    case (v)
      V0: return 2'b00;
      V1: return 2'b11;
      default: return unk_code;
    endcase
  endfunction

  function automatic tv_e ref_and(tv_e x, tv_e y);
    if (x == V0 || y == V0) return V0;
    if (x == V1 && y == V1) return V1;
    return VX;
  endfunction

  function automatic tv_e ref_or(tv_e x, tv_e y);
    if (x == V1 || y == V1) return V1;
    if (x == V0 && y == V0) return V0;
    return VX;
  endfunction

  function automatic tv_e ref_not(tv_e x);
    return (x == V0) ? V1 : (x == V1) ? V0 : VX;
  endfunction

  task automatic check(string req, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] a, logic [1:0] b, logic bn, logic [1:0] c);
    item_t it;
    tv_e ta, tb, tn;
    ta = to_tv(a);
    tb = to_tv(b);
    it.a = a; it.b = b; it.bn = bn; it.c = c;
    it.e_enc = bn ? 2'b11 : 2'b00;
    tn = ref_not(ta);
    it.e_not = (ta == VX) ? {a[0], a[1]} : from_tv(tn, 2'b00);
    it.e_and  = from_tv(ref_and(ta, tb), 2'b10);
    it.e_or   = from_tv(ref_or(ta, tb), 2'b01);
    it.e_nand = from_tv(ref_not(ref_and(ta, tb)), 2'b01);
    it.e_nor  = from_tv(ref_not(ref_or(ta, tb)), 2'b10);
    it.e_unk = (to_tv(c) == VX);
    it.e_val = (to_tv(c) == V1);
    @(negedge clk);
    opa = a; opb = b; bin = bn; cls = c;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check("R2", "encoder", enc, it.e_enc);
      check("R3", "inverter", nt, it.e_not);
      if (to_tv(it.a) == V0 || to_tv(it.b) == V0)
        check("R4", "and control", an, it.e_and);
      else
        check("R5", "and result", an, it.e_and);
      if (to_tv(it.a) == V1 || to_tv(it.b) == V1)
        check("R6", "or control", orr, it.e_or);
      else
        check("R7", "or result", orr, it.e_or);
      check("R8", "nand", nan, it.e_nand);
      check("R8", "nor", nr, it.e_nor);
      check("R9", "class unknown", {1'b0, unk}, {1'b0, it.e_unk});
      check("R9", "class value", {1'b0, val}, {1'b0, it.e_val});
    end
  end

  initial begin
    opa = 2'b00; opb = 2'b00; bin = 1'b0; cls = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    // R1 quiet state: all-zero inputs give definite zero outputs
    check("R1", "idle and", an, 2'b00);
    check("R1", "idle enc", enc, 2'b00);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      drive(i[3:2], i[1:0], i[0], i[3:2]);
    end
    for (int i = 0; i < 4; i++) begin
      drive(i[1:0], 2'b10, i[1], 2'b11 - i[1:0]);
    end
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule